// File: doc/BRIEF.md
# Line Uniformity Statistics Unit

This unit watches one scan line of pixel samples go past and works out, in a single pass, a set of figures that describe how even the line is. It tracks the brightest and darkest sample, the sum of all samples, and the largest step between neighbouring samples. From these it produces the line mean and a dark-uniformity figure. It also gives two ratios against the mean, both as fixed-point percentages: half the peak-to-peak spread, and the worst neighbour step.

Samples arrive with a valid strobe. The first sample of a line carries a start marker and the last carries an end marker. A line holds up to 10700 samples. Once the end marker is seen, one restoring divider is used three times in a row: first for the mean, then for each ratio. The whole result set is then published in one clock edge, together with a one-cycle done pulse. The delay from the end marker to done is always the same.

Top module: `line_stats`

## Requirements
- R1: After reset every result output is zero and `o_done` is low.
- R2: `o_max` and `o_min` are the largest and smallest accepted sample of the line.
- R3: `o_mean` is the floor of the sum of the accepted samples divided by their number.
- R4: `o_step` is the largest absolute difference between two consecutive accepted samples. The first sample of a line forms no step, so a one-sample line reports 0.
- R5: `o_spread_pct` is floor((max - min) * 12800 / mean). This is (max-min)/2/mean*100 with 8 fraction bits, so bits 7:0 are the fraction.
- R6: `o_step_pct` is floor(step * 25600 / mean). This is step/mean*100 with 8 fraction bits.
- R7: `o_dark` is the larger of (max - mean) and (mean - min).
- R8: `o_done` is high for exactly one cycle, at the 3*DIV_W+4'th rising edge after the edge that accepts the end-marked sample. Result outputs change only at the edge that raises `o_done`.
- R9: A cycle with `i_valid` low has no effect on any statistic, whatever `i_pix`, `i_sol` or `i_eol` carry.
- R10: When the mean is 0, both ratio outputs are all ones (2^DIV_W - 1).
- R11: A start-marked sample discards everything gathered before it. A line cut short by a new start marker therefore reports only the samples from the new marker onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | Sample on `i_pix` is accepted this cycle |
| i_sol | input | 1 | Accepted sample is the first of a line |
| i_eol | input | 1 | Accepted sample is the last of a line |
| i_pix | input | PIX_W | Sample value |
| o_done | output | 1 | One-cycle pulse: result outputs were just updated |
| o_max | output | PIX_W | Largest sample of the line |
| o_min | output | PIX_W | Smallest sample of the line |
| o_mean | output | PIX_W | Floor of the line mean |
| o_step | output | PIX_W | Largest neighbour difference |
| o_dark | output | PIX_W | Largest deviation of max or min from the mean |
| o_spread_pct | output | DIV_W | Half-spread over mean, percent, 8 fraction bits |
| o_step_pct | output | DIV_W | Worst step over mean, percent, 8 fraction bits |

## Verification
Every result of a line arrives together, 3*DIV_W+4 edges after the end-marked sample is accepted. With the default 32-bit divider that is 100 edges. When the bench drives an end marker, it files the expected figures in a queue together with the cycle count at which done must appear. The monitor samples on the falling edge and compares a popped entry only when done is high. It also checks that the cycle count matches, so a late or early result is caught even when the values are correct. The bench leaves at least that many cycles after each line before the next end marker. Outputs read in the middle of a following line must still hold the previous result.

// File: rtl/line_stats_pkg.sv
// Shared definitions for the line statistics unit.
// Assumes: nothing beyond IEEE 1800-2017.
package line_stats_pkg;

    // Post-line sequencing: which quotient the divider is producing.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_MEAN   = 2'd1,
        PH_SPREAD = 2'd2,
        PH_STEP   = 2'd3
    } phase_t;

    // Absolute difference of two unsigned values of the same width.
    function automatic logic [31:0] absdiff32(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/line_stats_acc.sv
// Streaming accumulator: tracks max, min, sum, count and the worst
// neighbour step of the current line.
// Assumes: a start-marked accepted sample opens a line; o_line_end pulses
// one cycle after an end-marked sample is accepted.
module line_stats_acc #(
    parameter int PIX_W = 12,
    parameter int CNT_W = 14,
    parameter int SUM_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_valid,
    input  logic             i_sol,
    input  logic             i_eol,
    input  logic [PIX_W-1:0] i_pix,
    output logic [PIX_W-1:0] o_max,
    output logic [PIX_W-1:0] o_min,
    output logic [PIX_W-1:0] o_step,
    output logic [SUM_W-1:0] o_sum,
    output logic [CNT_W-1:0] o_cnt,
    output logic             o_line_end
);
    import line_stats_pkg::*;

    logic [PIX_W-1:0] prev_q;
    logic [PIX_W-1:0] diff;

    // Magnitude of the step from the previous sample to this one.
    always_comb begin
        diff = PIX_W'(absdiff32(32'(i_pix), 32'(prev_q)));
    end

    // Update running statistics on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_max      <= '0;
            o_min      <= '0;
            o_step     <= '0;
            o_sum      <= '0;
            o_cnt      <= '0;
            prev_q     <= '0;
            o_line_end <= 1'b0;
        end else begin
            o_line_end <= i_valid & i_eol;
            if (i_valid) begin
                prev_q <= i_pix;
                if (i_sol) begin
                    o_max  <= i_pix;
                    o_min  <= i_pix;
                    o_step <= '0;
                    o_sum  <= SUM_W'(i_pix);
                    o_cnt  <= CNT_W'(1);
                end else begin
                    if (i_pix > o_max) o_max <= i_pix;
                    if (i_pix < o_min) o_min <= i_pix;
                    if (diff > o_step) o_step <= diff;
                    o_sum <= o_sum + SUM_W'(i_pix);
                    o_cnt <= o_cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/line_stats_div.sv
// Restoring divider producing one quotient bit per cycle.
// Assumes: i_start loads operands; o_fin pulses one cycle after the
// DW'th iteration edge. A zero divisor yields an all-ones quotient.
module line_stats_div #(
    parameter int DW = 32,
    parameter int VW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_start,
    input  logic [DW-1:0] i_dividend,
    input  logic [VW-1:0] i_divisor,
    output logic [DW-1:0] o_quot,
    output logic          o_fin
);
    localparam int CW = $clog2(DW + 1);

    logic [VW-1:0] rem_q;
    logic [VW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic [VW:0]   shifted;
    logic          ge;
    logic [VW:0]   trial;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        shifted = {rem_q, o_quot[DW-1]};
        ge      = (shifted >= {1'b0, dvs_q});
        trial   = shifted - {1'b0, dvs_q};
    end

    // Load operands on start, then iterate DW times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            o_quot <= '0;
            o_fin  <= 1'b0;
        end else begin
            o_fin <= 1'b0;
            if (i_start) begin
                rem_q  <= '0;
                dvs_q  <= i_divisor;
                o_quot <= i_dividend;
                cnt_q  <= CW'(DW);
            end else if (cnt_q != '0) begin
                rem_q  <= ge ? trial[VW-1:0] : shifted[VW-1:0];
                o_quot <= {o_quot[DW-2:0], ge};
                cnt_q  <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) o_fin <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/line_stats.sv
// Line uniformity statistics: streams one line, then runs three
// divisions (mean, spread ratio, step ratio) and publishes all results
// at once with a done pulse 3*DIV_W+4 edges after the end marker.
// Assumes: the next end marker arrives no earlier than that done pulse.
module line_stats #(
    parameter int PIX_W   = 12,
    parameter int MAX_PIX = 10700,
    parameter int DIV_W   = 32,
    parameter int FRAC    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_valid,
    input  logic             i_sol,
    input  logic             i_eol,
    input  logic [PIX_W-1:0] i_pix,
    output logic             o_done,
    output logic [PIX_W-1:0] o_max,
    output logic [PIX_W-1:0] o_min,
    output logic [PIX_W-1:0] o_mean,
    output logic [PIX_W-1:0] o_step,
    output logic [PIX_W-1:0] o_dark,
    output logic [DIV_W-1:0] o_spread_pct,
    output logic [DIV_W-1:0] o_step_pct
);
    import line_stats_pkg::*;

    localparam int CNT_W    = $clog2(MAX_PIX + 1);
    localparam int SUM_W    = PIX_W + CNT_W;
    localparam int VW       = (CNT_W > PIX_W) ? CNT_W : PIX_W;
    localparam int SPREAD_K = 50 << FRAC;
    localparam int STEP_K   = 100 << FRAC;

    logic [PIX_W-1:0] acc_max, acc_min, acc_step;
    logic [SUM_W-1:0] acc_sum;
    logic [CNT_W-1:0] acc_cnt;
    logic             acc_end;

    logic             div_start, div_fin;
    logic [DIV_W-1:0] div_num, div_quot;
    logic [VW-1:0]    div_den;

    phase_t           phase_q;
    logic [PIX_W-1:0] snap_max, snap_min, snap_step, mean_q;
    logic [DIV_W-1:0] spread_q;
    logic [PIX_W-1:0] dark_c;

    line_stats_acc #(.PIX_W(PIX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sol(i_sol),
        .i_eol(i_eol), .i_pix(i_pix), .o_max(acc_max), .o_min(acc_min),
        .o_step(acc_step), .o_sum(acc_sum), .o_cnt(acc_cnt),
        .o_line_end(acc_end)
    );

    line_stats_div #(.DW(DIV_W), .VW(VW)) u_div (
        .clk(clk), .rst_n(rst_n), .i_start(div_start),
        .i_dividend(div_num), .i_divisor(div_den),
        .o_quot(div_quot), .o_fin(div_fin)
    );

    // Choose divider operands and start condition for each phase.
    always_comb begin
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        case (phase_q)
            PH_IDLE: begin
                div_start = acc_end;
                div_num   = DIV_W'(acc_sum);
                div_den   = VW'(acc_cnt);
            end
            PH_MEAN: begin
                div_start = div_fin;
                div_num   = DIV_W'(snap_max - snap_min) * DIV_W'(SPREAD_K);
                div_den   = VW'(div_quot[PIX_W-1:0]);
            end
            PH_SPREAD: begin
                div_start = div_fin;
                div_num   = DIV_W'(snap_step) * DIV_W'(STEP_K);
                div_den   = VW'(mean_q);
            end
            default: ;
        endcase
    end

    // Largest deviation of the extremes from the mean.
    always_comb begin
        dark_c = ((snap_max - mean_q) > (mean_q - snap_min)) ?
                 (snap_max - mean_q) : (mean_q - snap_min);
    end

    // Sequence the three divisions and publish results atomically.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            snap_max     <= '0;
            snap_min     <= '0;
            snap_step    <= '0;
            mean_q       <= '0;
            spread_q     <= '0;
            o_done       <= 1'b0;
            o_max        <= '0;
            o_min        <= '0;
            o_mean       <= '0;
            o_step       <= '0;
            o_dark       <= '0;
            o_spread_pct <= '0;
            o_step_pct   <= '0;
        end else begin
            o_done <= 1'b0;
            case (phase_q)
                PH_IDLE: if (acc_end) begin
                    snap_max  <= acc_max;
                    snap_min  <= acc_min;
                    snap_step <= acc_step;
                    phase_q   <= PH_MEAN;
                end
                PH_MEAN: if (div_fin) begin
                    mean_q  <= div_quot[PIX_W-1:0];
                    phase_q <= PH_SPREAD;
                end
                PH_SPREAD: if (div_fin) begin
                    spread_q <= div_quot;
                    phase_q  <= PH_STEP;
                end
                default: if (div_fin) begin
                    o_done       <= 1'b1;
                    o_max        <= snap_max;
                    o_min        <= snap_min;
                    o_mean       <= mean_q;
                    o_step       <= snap_step;
                    o_dark       <= dark_c;
                    o_spread_pct <= spread_q;
                    o_step_pct   <= div_quot;
                    phase_q      <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/line_stats_chk.sv
// Property checker for line_stats, attached by bind.
// Assumes: observes top-level ports only.
module line_stats_chk #(
    parameter int PIX_W = 12,
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             o_done,
    input logic [PIX_W-1:0] o_max,
    input logic [PIX_W-1:0] o_min,
    input logic [PIX_W-1:0] o_mean,
    input logic [PIX_W-1:0] o_step,
    input logic [PIX_W-1:0] o_dark,
    input logic [DIV_W-1:0] o_spread_pct,
    input logic [DIV_W-1:0] o_step_pct
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |=> !o_done);

    assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !o_done |-> ($stable(o_max) && $stable(o_min) && $stable(o_mean) &&
                     $stable(o_step) && $stable(o_dark) &&
                     $stable(o_spread_pct) && $stable(o_step_pct)));

    assert_min_le_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> (o_min <= o_max));

    assert_mean_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> ((o_mean >= o_min) && (o_mean <= o_max)));

    assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> (o_step <= (o_max - o_min)));

    assert_dark_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> (o_dark <= (o_max - o_min)));

endmodule

bind line_stats line_stats_chk #(.PIX_W(PIX_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .o_done(o_done), .o_max(o_max),
    .o_min(o_min), .o_mean(o_mean), .o_step(o_step), .o_dark(o_dark),
    .o_spread_pct(o_spread_pct), .o_step_pct(o_step_pct)
);

// File: tb/test_line_stats.sv
// Scoreboard bench: the driver files expected results, the monitor
// compares them on the done pulse and checks its arrival cycle.
module test_line_stats;
    localparam int PIX_W = 12;
    localparam int DIV_W = 32;
    localparam int LAT   = 3 * DIV_W + 5;

    typedef struct {
        longint mx, mn, mean, step, dark, spr, stp, due;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             i_valid = 1'b0, i_sol = 1'b0, i_eol = 1'b0;
    logic [PIX_W-1:0] i_pix = '0;
    logic             o_done;
    logic [PIX_W-1:0] o_max, o_min, o_mean, o_step, o_dark;
    logic [DIV_W-1:0] o_spread_pct, o_step_pct;

    exp_t   sb[$];
    exp_t   last;
    int     pq[$];
    longint cyc = 0;
    int     n_chk = 0, n_bad = 0;
    bit     ended = 0;

    line_stats i_line_stats (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sol(i_sol),
        .i_eol(i_eol), .i_pix(i_pix), .o_done(o_done), .o_max(o_max),
        .o_min(o_min), .o_mean(o_mean), .o_step(o_step), .o_dark(o_dark),
        .o_spread_pct(o_spread_pct), .o_step_pct(o_step_pct)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Drive one cycle of input.
    task automatic drive(input bit v, input bit s, input bit e, input int d);
        @(negedge clk);
        i_valid = v; i_sol = s; i_eol = e; i_pix = PIX_W'(d);
    endtask

    // Prefix samples that a later start marker must discard (R11).
    task automatic send_prefix();
        foreach (pq[k]) drive(1, k == 0, 0, pq[k]);
    endtask

    // Send the line in pq; gap inserts an invalid junk cycle after each sample.
    task automatic send_line(input bit gap);
        exp_t   x;
        longint sum = 0;
        x.mx = pq[0]; x.mn = pq[0]; x.step = 0;
        foreach (pq[k]) begin
            longint d;
            sum += pq[k];
            if (pq[k] > x.mx) x.mx = pq[k];
            if (pq[k] < x.mn) x.mn = pq[k];
            if (k > 0) begin
                d = (pq[k] > pq[k-1]) ? pq[k] - pq[k-1] : pq[k-1] - pq[k];
                if (d > x.step) x.step = d;
            end
        end
        x.mean = sum / pq.size();
        x.dark = ((x.mx - x.mean) > (x.mean - x.mn)) ? x.mx - x.mean : x.mean - x.mn;
        x.spr  = (x.mean == 0) ? 64'hFFFF_FFFF : ((x.mx - x.mn) * 12800) / x.mean;
        x.stp  = (x.mean == 0) ? 64'hFFFF_FFFF : (x.step * 25600) / x.mean;
        foreach (pq[k]) begin
            drive(1, k == 0, k == pq.size() - 1, pq[k]);
            if (k == pq.size() - 1) begin
                x.due = cyc + LAT;
                sb.push_back(x);
            end else if (gap) begin
                drive(0, 1, 1, 4095);
            end
        end
        drive(0, 0, 0, 0);
        repeat (LAT + 4) @(negedge clk);
    endtask

    // Monitor: compare results against the scoreboard on done.
    always @(negedge clk) begin
        if (rst_n && o_done) begin
            if (sb.size() == 0) begin
                chk("R8 unexpected done", 1, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                chk("R8 latency", cyc, x.due);
                chk("R2 max", o_max, x.mx);
                chk("R2 min", o_min, x.mn);
                chk("R3 mean", o_mean, x.mean);
                chk("R4 step", o_step, x.step);
                chk("R7 dark", o_dark, x.dark);
                chk("R5 spread pct / R10", o_spread_pct, x.spr);
                chk("R6 step pct / R10", o_step_pct, x.stp);
                last = x;
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", o_done, 0);
        chk("R1 max", o_max, 0);
        chk("R1 spread", o_spread_pct, 0);
        rst_n = 1'b1;

        // R2..R7: basic line
        pq = '{100, 300, 200, 50};
        send_line(0);

        // R9: invalid junk cycles between samples
        pq = '{500, 20, 900, 880, 35};
        send_line(1);

        // R4: one-sample line
        pq = '{777};
        send_line(0);

        // R10: all-zero line, mean 0
        pq = '{0, 0, 0};
        send_line(0);

        // R11 and R8 hold: restart mid-line; outputs keep last result
        pq = '{4095, 0, 4095};
        send_prefix();
        chk("R8 hold max", o_max, last.mx);
        chk("R8 hold mean", o_mean, last.mean);
        pq = '{10, 12, 11};
        send_line(0);

        // R5: flat line gives zero spread
        pq = '{1234, 1234, 1234, 1234};
        send_line(0);

        // R2..R6: full-length line
        pq.delete();
        for (int k = 0; k < 10700; k++) pq.push_back((k * 37 + (k % 3) * 500) % 4096);
        send_line(0);

        chk("R8 all results delivered", sb.size(), 0);
        finish_run();
    end
endmodule